// File: doc/BRIEF.md
# Register-Driven SPI Master with Word FIFOs

This block is an SPI bus master that software runs through five 32-bit registers on a small synchronous register port. Software queues words in a transmit FIFO. The shifter sends each queued word on SCLK and MOSI and samples MISO at the same time. Each word it receives goes into a receive FIFO, and software pops that FIFO by reading the receive-data register. The word width and the SCLK divider are elaboration parameters, and no register can change them.

A hold bit in the control register keeps queued words in the FIFO. Software can fill the FIFO completely, then clear the bit to send a burst of words back to back. Slave selects are active low. They come from a register and are either driven at all times (manual mode) or only while a word is shifting (automatic mode). Software chooses the clock polarity, the clock phase and the bit order. An internal loopback feeds MOSI back into the receiver.

Register index on `bus_addr`: 0 control, 1 status, 2 transmit data (write only), 3 receive data (read pops the FIFO), 4 slave select.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, control reads 0x100, status reads 0x05, `ss_n` is all ones and `sclk` is low.
- R2: Control bits are: 0 loopback, 1 enable, 2 master, 3 CPOL, 4 CPHA, 7 manual select, 8 hold, 9 LSB first. Every one of these bits, the loopback bit included, reads back exactly as written.
- R3: While bit 8 is 1, or while bit 1 or bit 2 is 0, `sclk` never toggles and no word leaves the transmit FIFO. Once bit 8 is cleared with bits 1 and 2 set, all queued words go out back to back.
- R4: `sclk` idles at CPOL. With CPHA=0, MOSI is valid before the first edge and MISO is sampled on leading edges. With CPHA=1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R5: Writing 1 to control bit 5 empties the transmit FIFO, and writing 1 to bit 6 empties the receive FIFO. Both bits always read back as 0.
- R6: The slave-select register is active low and resets to all ones. With bit 7 set, `ss_n` equals the register on every cycle. With bit 7 clear, `ss_n` is all ones except while a word is shifting.
- R7: Each word sent pushes one received word into the receive FIFO. Reading index 3 pops the FIFO, and a read of an empty FIFO returns 0.
- R8: With bit 9 set, words are shifted and assembled LSB first. Otherwise they are MSB first.
- R9: With bit 0 set, the receiver takes MOSI instead of MISO, so the received word equals the sent word.
- R10: Status bits are: 0 RX empty, 1 RX full, 2 TX empty, 3 TX full, 4 mode fault (always 0). A write to a full transmit FIFO is dropped, and TX full stays set until a word is consumed.
- R11: Each `sclk` half period lasts DIV clock cycles, and each word makes exactly 2*W edges.
- R12: A register read returns its data on `bus_rdata` one clock after the read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low slave selects |

## Verification
Register reads are due one clock after the strobe, so every bench read samples `bus_rdata` at the falling edge that follows the capturing rising edge. SPI edges appear in the same cycle as the divider tick that makes them. The bench slave watches `sclk` at each falling clock edge and updates MISO only after the master has sampled it, so the sampled bit is stable. A cycle-level model of the control and slave-select registers, updated on the same rising edges as the design, is compared with `ss_n` on every clock. Data results are checked only after a wait longer than the words in flight can take, which is (2*W*DIV+1) cycles per word.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int W     = 8,
  parameter int DIV   = 4,
  parameter int DEPTH = 16,
  parameter int NSS   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [2:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [NSS-1:0]  ss_n
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int HW  = $clog2(2 * W);
  localparam int DCW = $clog2(DIV + 1);

  logic [9:0]     ctrl;
  logic [NSS-1:0] sel_reg;
  logic [W-1:0]   tx_mem [DEPTH];
  logic [W-1:0]   rx_mem [DEPTH];
  logic [AW-1:0]  tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0]  tx_cnt, rx_cnt;
  logic           busy, sclk_q, mosi_q;
  logic [HW-1:0]  h;
  logic [DCW-1:0] dcnt;
  logic [W-1:0]   txs, rxs, rx_nxt, rx_word;

  wire lpbk = ctrl[0], cpol = ctrl[3], cpha = ctrl[4], manual = ctrl[7], lsb = ctrl[9];
  wire run_ok  = ctrl[1] & ctrl[2] & ~ctrl[8];
  wire wr_ctrl = bus_sel & bus_wr & (bus_addr == 3'd0);
  wire tx_clr  = wr_ctrl & bus_wdata[5];
  wire rx_clr  = wr_ctrl & bus_wdata[6];
  wire tx_full = (tx_cnt == CW'(DEPTH));
  wire rx_full = (rx_cnt == CW'(DEPTH));
  wire tx_empty = (tx_cnt == '0);
  wire rx_empty = (rx_cnt == '0);
  wire tx_push = bus_sel & bus_wr & (bus_addr == 3'd2) & ~tx_full;
  wire rx_pop  = bus_sel & ~bus_wr & (bus_addr == 3'd3) & ~rx_empty;
  wire start   = ~busy & run_ok & ~tx_empty & ~tx_clr;
  wire tick    = busy & (dcnt == DCW'(DIV - 1));
  wire lead    = tick & ~h[0];
  wire trail   = tick & h[0];
  wire last    = tick & (h == HW'(2 * W - 1));
  wire drv     = cpha ? lead : (trail & ~last);
  wire smp     = cpha ? trail : lead;
  wire rx_in   = lpbk ? mosi_q : miso;
  wire rx_push = last & ~rx_full;

  function automatic logic first_bit(input logic [W-1:0] x, input logic l);
    return l ? x[0] : x[W-1];
  endfunction
  function automatic logic [W-1:0] shift_word(input logic [W-1:0] x, input logic l);
    return l ? (x >> 1) : (x << 1);
  endfunction
  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rx_nxt  = lsb ? {rx_in, rxs[W-1:1]} : {rxs[W-2:0], rx_in};
  assign rx_word = smp ? rx_nxt : rxs;
  assign sclk    = sclk_q ^ cpol;
  assign mosi    = mosi_q;
  assign ss_n    = (manual | busy) ? sel_reg : '1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl    <= 10'h100;
      sel_reg <= '1;
    end else if (bus_sel && bus_wr) begin
      if (bus_addr == 3'd0) ctrl <= bus_wdata[9:0] & ~10'h060;
      if (bus_addr == 3'd4) sel_reg <= bus_wdata[NSS-1:0];
    end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[W-1:0];
    if (rx_push) rx_mem[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (start)   tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(start);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; h <= '0; dcnt <= '0; sclk_q <= 1'b0;
      mosi_q <= 1'b0; txs <= '0; rxs <= '0;
    end else if (start) begin
      busy <= 1'b1; h <= '0; dcnt <= '0; sclk_q <= 1'b0;
      if (!cpha) begin
        mosi_q <= first_bit(tx_mem[tx_rp], lsb);
        txs    <= shift_word(tx_mem[tx_rp], lsb);
      end else begin
        txs <= tx_mem[tx_rp];
      end
    end else if (busy) begin
      if (tick) begin
        dcnt   <= '0;
        sclk_q <= ~sclk_q;
        h      <= h + 1'b1;
        if (last) busy <= 1'b0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
      if (drv) begin
        mosi_q <= first_bit(txs, lsb);
        txs    <= shift_word(txs, lsb);
      end
      if (smp) rxs <= rx_nxt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (bus_sel && !bus_wr)
      case (bus_addr)
        3'd0:    bus_rdata <= 32'(ctrl);
        3'd1:    bus_rdata <= 32'({1'b0, tx_full, tx_empty, rx_full, rx_empty});
        3'd3:    bus_rdata <= rx_empty ? '0 : 32'(rx_mem[rx_rp]);
        3'd4:    bus_rdata <= 32'(sel_reg);
        default: bus_rdata <= '0;
      endcase
    else bus_rdata <= '0;
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int DEPTH = 16,
  parameter int NSS   = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         busy,
  input logic                         sclk,
  input logic                         cpol,
  input logic                         inhibit,
  input logic                         manual,
  input logic [NSS-1:0]               ss_n,
  input logic [$clog2(DEPTH+1)-1:0]   tx_cnt,
  input logic                         tx_wr,
  input logic                         rd_ctrl,
  input logic [31:0]                  bus_rdata
);
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol); // R4
  AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !busy) |=> !busy); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == DEPTH && tx_wr && inhibit) |=> tx_cnt == DEPTH); // R10
  AST_CLR_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |=> bus_rdata[6:5] == 2'b00); // R5
  AST_AUTO_SS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual && !busy) |-> &ss_n); // R6
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH), .NSS(NSS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .cpol(ctrl[3]),
  .inhibit(ctrl[8]), .manual(ctrl[7]), .ss_n(ss_n), .tx_cnt(tx_cnt),
  .tx_wr(bus_sel && bus_wr && bus_addr == 3'd2),
  .rd_ctrl(bus_sel && !bus_wr && bus_addr == 3'd0),
  .bus_rdata(bus_rdata)
);

// File: tb/spi_fifo_master_bench.sv
`timescale 1ns/1ps
module spi_fifo_master_bench;
  localparam int W = 8, DIV = 4, DEPTH = 16, NSS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sclk, mosi, miso;
  logic [NSS-1:0] ss_n;

  always #4 clk = ~clk;

  spi_fifo_master #(.W(W), .DIV(DIV), .DEPTH(DEPTH), .NSS(NSS)) u_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .ss_n(ss_n));

  int checks = 0, errors = 0, ss_bad = 0;
  bit done = 0;

  // reference model of the writable registers, advanced on the design's edges
  logic [9:0] mc;
  logic [NSS-1:0] m_ss;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin mc <= 10'h100; m_ss <= '1; end
    else if (bus_sel && bus_wr) begin
      if (bus_addr == 3'd0) mc <= bus_wdata[9:0] & ~10'h060;
      if (bus_addr == 3'd4) m_ss <= bus_wdata[NSS-1:0];
    end

  // SPI slave model
  logic [W-1:0] sw = '0, cap = '0;
  logic [W-1:0] sq[$], got[$];
  int sidx = 0, edges = 0, gmin = 1000000, last_edge = 0, cyc = 0;
  logic psclk = 1'b0;
  assign miso = mc[9] ? sw[sidx] : sw[W-1-sidx];

  always @(negedge clk) begin
    cyc++;
    if (rst_n && sclk !== psclk && !(&ss_n)) begin
      edges++;
      if (cyc - last_edge < gmin) gmin = cyc - last_edge;
      last_edge = cyc;
      if (mc[4] ? (sclk == mc[3]) : (sclk != mc[3])) begin
        cap = mc[9] ? {mosi, cap[W-1:1]} : {cap[W-2:0], mosi};
        sidx++;
        if (sidx == W) begin
          got.push_back(cap);
          sidx = 0;
          sw = (sq.size() > 0) ? sq.pop_front() : '0;
        end
      end
    end
    psclk = sclk;
    if (rst_n && mc[7] && ss_n !== m_ss) ss_bad++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_sel = 0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prime(input logic [W-1:0] first);
    got.delete(); sq.delete(); sidx = 0; sw = first; edges = 0; gmin = 1000000; last_edge = cyc;
  endtask

  logic [31:0] d;

  initial begin
    waitc(5); rst_n = 1;
    rd(3'd0, d); chk("R1 ctrl reset / R12 latency", d, 32'h100);
    rd(3'd1, d); chk("R1 status reset", d, 32'h05);
    chk("R1 ss_n reset", 32'(ss_n), 32'hF);
    chk("R1 sclk reset", 32'(sclk), 0);

    wr(3'd0, 32'h101); rd(3'd0, d); chk("R2 loopback readback", d, 32'h101);
    wr(3'd0, 32'h39F); rd(3'd0, d); chk("R2 full readback", d, 32'h39F);
    wr(3'd0, 32'h160); rd(3'd0, d); chk("R5 clear bits read 0", d, 32'h100);

    // mode 0, MSB first, manual select
    wr(3'd0, 32'h186); wr(3'd4, 32'hE);
    prime(8'h5A); sq.push_back(8'hC3); sq.push_back(8'hFF);
    wr(3'd2, 32'hA5); wr(3'd2, 32'h3C); wr(3'd2, 32'h01);
    waitc(100);
    chk("R3 no edges while held", edges, 0);
    rd(3'd1, d); chk("R3 words kept while held", d, 32'h01);
    wr(3'd0, 32'h086); waitc(300);
    chk("R4 mode0 word count", got.size(), 3);
    if (got.size() == 3) begin
      chk("R4 mode0 word0", got[0], 8'hA5);
      chk("R4 mode0 word1", got[1], 8'h3C);
      chk("R4 mode0 word2", got[2], 8'h01);
    end
    chk("R11 edges per word", edges, 3 * 2 * W);
    chk("R11 half period", gmin, DIV);
    chk("R4 idle low", 32'(sclk), 0);
    rd(3'd3, d); chk("R7 rx word0", d, 32'h5A);
    rd(3'd3, d); chk("R7 rx word1", d, 32'hC3);
    rd(3'd3, d); chk("R7 rx word2", d, 32'hFF);
    rd(3'd3, d); chk("R7 empty read", d, 0);
    rd(3'd1, d); chk("R7 status drained", d, 32'h05);
    chk("R6 manual ss", 32'(ss_n), 32'hE);

    // mode 3, LSB first
    wr(3'd4, 32'hF); wr(3'd0, 32'h39E); wr(3'd4, 32'hD);
    prime(8'h37); sq.push_back(8'hE2);
    wr(3'd2, 32'h81); wr(3'd2, 32'h4E);
    wr(3'd0, 32'h29E); waitc(200);
    chk("R8 mode3 lsb count", got.size(), 2);
    if (got.size() == 2) begin
      chk("R8 mode3 lsb word0", got[0], 8'h81);
      chk("R8 mode3 lsb word1", got[1], 8'h4E);
    end
    chk("R4 idle high", 32'(sclk), 1);
    rd(3'd3, d); chk("R8 lsb rx word0", d, 32'h37);
    rd(3'd3, d); chk("R8 lsb rx word1", d, 32'hE2);

    // mode 2
    wr(3'd4, 32'hF); wr(3'd0, 32'h18E); wr(3'd4, 32'hB);
    prime(8'h6B); wr(3'd2, 32'h96); wr(3'd0, 32'h08E); waitc(100);
    chk("R4 mode2 tx", got.size() > 0 ? 32'(got[0]) : 32'hDEAD, 32'h96);
    rd(3'd3, d); chk("R4 mode2 rx", d, 32'h6B);

    // mode 1
    wr(3'd4, 32'hF); wr(3'd0, 32'h196); wr(3'd4, 32'h7);
    prime(8'h2D); wr(3'd2, 32'hD2); wr(3'd0, 32'h096); waitc(100);
    chk("R4 mode1 tx", got.size() > 0 ? 32'(got[0]) : 32'hDEAD, 32'hD2);
    rd(3'd3, d); chk("R4 mode1 rx", d, 32'h2D);
    chk("R4 mode1 idle low", 32'(sclk), 0);

    // loopback
    wr(3'd4, 32'hF); wr(3'd0, 32'h187); wr(3'd4, 32'hE);
    prime(8'h00); wr(3'd2, 32'h5C); wr(3'd0, 32'h087); waitc(100);
    rd(3'd3, d); chk("R9 loopback rx", d, 32'h5C);

    // enable off blocks shifting
    wr(3'd0, 32'h084); prime(8'h00); wr(3'd2, 32'h33); waitc(100);
    chk("R3 disabled no edges", edges, 0);
    wr(3'd0, 32'h0A4);
    rd(3'd1, d); chk("R5 tx clear", d, 32'h05);

    // automatic select
    wr(3'd4, 32'hF); wr(3'd0, 32'h106); wr(3'd4, 32'hB);
    prime(8'h99); wr(3'd2, 32'h42); waitc(10);
    chk("R6 auto idle deselect", 32'(ss_n), 32'hF);
    wr(3'd0, 32'h006); waitc(15);
    chk("R6 auto select during word", 32'(ss_n), 32'hB);
    waitc(80);
    chk("R6 auto deselect after", 32'(ss_n), 32'hF);
    chk("R6 auto word sent", got.size() > 0 ? 32'(got[0]) : 32'hDEAD, 32'h42);
    rd(3'd3, d); chk("R7 auto rx", d, 32'h99);

    // full transmit FIFO
    wr(3'd0, 32'h186); wr(3'd4, 32'hE); prime(8'h00);
    for (int i = 0; i < DEPTH + 1; i++) wr(3'd2, 32'(i + 1));
    rd(3'd1, d); chk("R10 tx full", d, 32'h09);
    wr(3'd0, 32'h086); waitc(1200);
    chk("R10 sent count", got.size(), DEPTH);
    chk("R10 last kept word", got.size() == DEPTH ? 32'(got[DEPTH-1]) : 32'hDEAD, DEPTH);
    rd(3'd1, d); chk("R7 rx full", d, 32'h06);
    wr(3'd0, 32'h0C6);
    rd(3'd1, d); chk("R5 rx clear", d, 32'h05);
    rd(3'd0, d); chk("R5 self clear", d, 32'h086);

    // transmit clear while held
    wr(3'd0, 32'h186); prime(8'h00);
    wr(3'd2, 32'h11); wr(3'd2, 32'h22);
    wr(3'd0, 32'h1A6); wr(3'd0, 32'h086); waitc(150);
    chk("R5 cleared words not sent", edges, 0);

    chk("R6 per-cycle ss", ss_bad, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule